// File: doc/BRIEF.md
# Video Clamp and Automatic Gain Controller

This block is the digital control loop of one analog video input channel. It watches the 9-bit converter samples that arrive on a sample-rate enable. From them it produces two things. The first is a pair of clamp commands, raise or lower, that steer the coupling-capacitor clamp toward a black level chosen by the source type. The second is a 9-bit gain code for the input amplifier.

Clamp decisions are made only inside the horizontal clamp window on the back porch. The gain loop looks at the sync tip once per line. It also reacts at once to any sample that runs past the white peak.

The gain is integrated in a wide saturating accumulator, and its upper bits form the actual gain value. The amplifier does not follow that value directly. It is driven by a held copy that moves only when the actual value has drifted by at least a programmable amount. Both loops stop during vertical blanking. With automatic gain off, a static register value drives the amplifier instead.

Top module: `vcag_top`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), both clamp outputs are 0. The accumulator holds its mid-range value 2^(ACC_W-1), and with agc_on=1 the gain code reads 256.
- R2: The clamp target is selected by src_kind: codes 0 and 1 (composite, separated luma) give 120; codes 2 and 3 (chroma, colour-difference components) give 256; codes 4 and 5 (component luma, RGB) give 32; codes 6 and 7 give 120.
- R3: On an enabled sample with hclamp=1 and vblank=0, clamp_up becomes 1 when the sample is below the target and clamp_dn becomes 1 when it is above. Both become 0 when the sample equals the target or when hclamp=0. The outputs change one clock after the sample.
- R4: On an enabled sample with vblank=1, both clamp outputs become 0, and neither the accumulator nor the held gain changes.
- R5: With agc_on=1 and vblank=0, every enabled sample of code 511 (above the white peak 510) lowers the accumulator by one actual-gain step, 2^(ACC_W-9), whether or not hsync is high.
- R6: With agc_on=1 and vblank=0, only the first enabled sample of each hsync pulse is evaluated. A code above 4 adds one accumulator LSB, code 0 removes one, and codes 1 to 4 change nothing. The white-peak rule of R5 takes precedence over this evaluation.
- R7: With agc_on=1, gain_code equals the held gain. On each enabled sample outside vblank, the held gain is loaded with the actual gain (the accumulator's top 9 bits before that sample's update) when the absolute difference between them is at least upd_lvl.
- R8: The accumulator saturates at 0 and at 2^ACC_W-1 instead of wrapping.
- R9: With agc_on=0, gain_code equals man_gain and the accumulator does not change.
- R10: Cycles with smp_en=0 change no state and no output except the combinational gain_code selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_en | input | 1 | Sample-rate enable |
| adc_code | input | 9 | Converter sample |
| hclamp | input | 1 | Horizontal clamp window |
| hsync | input | 1 | Horizontal sync pulse |
| vblank | input | 1 | Vertical blanking pulse |
| src_kind | input | 3 | Source type selecting the clamp target |
| agc_on | input | 1 | Automatic gain enable |
| man_gain | input | 9 | Static gain used when agc_on is 0 |
| upd_lvl | input | 9 | Minimum drift that refreshes the held gain |
| clamp_up | output | 1 | Raise clamp level |
| clamp_dn | output | 1 | Lower clamp level |
| gain_code | output | 9 | Amplifier gain code |

## Verification
The hardest state to reach from the ports is the upper saturation of the accumulator. The only way to raise the gain is one LSB per line, so at the full 18-bit width that takes far more lines than a run can afford. The bench therefore builds the block with a 12-bit accumulator, keeping the same 9-bit gain. It then drives a few thousand short sync pulses with a tall sync tip until the gain pins at 511. A single white-peak sample afterwards shows that the value steps down by one and does not wrap.

// File: rtl/vcag_pkg.sv
package vcag_pkg;
    localparam int CODE_W = 9;

    typedef enum logic [2:0] {
        SRC_COMPOSITE = 3'd0,
        SRC_SEP_LUMA  = 3'd1,
        SRC_CHROMA    = 3'd2,
        SRC_DIFF      = 3'd3,
        SRC_COMP_Y    = 3'd4,
        SRC_RGB       = 3'd5,
        SRC_RSVD6     = 3'd6,
        SRC_RSVD7     = 3'd7
    } src_kind_e;

    function automatic logic [CODE_W-1:0] clamp_target(input src_kind_e k);
        case (k)
            SRC_CHROMA, SRC_DIFF:  clamp_target = CODE_W'(256);
            SRC_COMP_Y, SRC_RGB:   clamp_target = CODE_W'(32);
            default:               clamp_target = CODE_W'(120);
        endcase
    endfunction
endpackage

// File: rtl/vcag_clamp.sv
module vcag_clamp
    import vcag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic              vblank,
    input  logic              hclamp,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] target,
    output logic              up,
    output logic              dn
);
    typedef struct packed {
        logic up;
        logic dn;
    } clamp_st_t;

    clamp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (smp_en) begin
            st_d.up = 1'b0;
            st_d.dn = 1'b0;
            if (!vblank && hclamp) begin
                st_d.up = (code < target);
                st_d.dn = (code > target);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up = st_q.up;
    assign dn = st_q.dn;
endmodule

// File: rtl/vcag_gain_acc.sv
module vcag_gain_acc
    import vcag_pkg::*;
#(
    parameter int ACC_W    = 18,
    parameter int WHITE_PK = 510,
    parameter int SYNC_REF = 1,
    parameter int SYNC_HI  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic              vblank,
    input  logic              agc_on,
    input  logic              hsync,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] agv
);
    localparam int FRAC_W = ACC_W - CODE_W;
    localparam logic [ACC_W-1:0] STEP    = ACC_W'(1) << FRAC_W;
    localparam logic [ACC_W-1:0] ACC_MID = ACC_W'(1) << (ACC_W - 1);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;
    localparam logic [CODE_W-1:0] PK_C  = CODE_W'(WHITE_PK);
    localparam logic [CODE_W-1:0] REF_C = CODE_W'(SYNC_REF);
    localparam logic [CODE_W-1:0] HI_C  = CODE_W'(SYNC_HI);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             hs_prev;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic    line_eval;

    assign line_eval = hsync && !st_q.hs_prev;

    always_comb begin
        st_d = st_q;
        if (smp_en) begin
            st_d.hs_prev = hsync;
            if (agc_on && !vblank) begin
                if (code > PK_C) begin
                    st_d.acc = (st_q.acc < STEP) ? '0 : st_q.acc - STEP;
                end else if (line_eval) begin
                    if (code > HI_C)
                        st_d.acc = (st_q.acc == ACC_MAX) ? ACC_MAX : st_q.acc + 1'b1;
                    else if (code < REF_C)
                        st_d.acc = (st_q.acc == '0) ? '0 : st_q.acc - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.acc     <= ACC_MID;
            st_q.hs_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign agv = st_q.acc[ACC_W-1 -: CODE_W];
endmodule

// File: rtl/vcag_gain_hold.sv
module vcag_gain_hold
    import vcag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic              vblank,
    input  logic [CODE_W-1:0] agv,
    input  logic [CODE_W-1:0] upd_lvl,
    output logic [CODE_W-1:0] fgv
);
    localparam logic [CODE_W-1:0] GAIN_MID = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        logic [CODE_W-1:0] fgv;
    } hold_st_t;

    hold_st_t          st_d, st_q;
    logic [CODE_W-1:0] drift;

    assign drift = (agv > st_q.fgv) ? agv - st_q.fgv : st_q.fgv - agv;

    always_comb begin
        st_d = st_q;
        if (smp_en && !vblank && (drift >= upd_lvl))
            st_d.fgv = agv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.fgv <= GAIN_MID;
        else        st_q     <= st_d;
    end

    assign fgv = st_q.fgv;
endmodule

// File: rtl/vcag_top.sv
module vcag_top
    import vcag_pkg::*;
#(
    parameter int ACC_W    = 18,
    parameter int WHITE_PK = 510,
    parameter int SYNC_REF = 1,
    parameter int SYNC_HI  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_en,
    input  logic [8:0] adc_code,
    input  logic       hclamp,
    input  logic       hsync,
    input  logic       vblank,
    input  logic [2:0] src_kind,
    input  logic       agc_on,
    input  logic [8:0] man_gain,
    input  logic [8:0] upd_lvl,
    output logic       clamp_up,
    output logic       clamp_dn,
    output logic [8:0] gain_code
);
    logic [CODE_W-1:0] target;
    logic [CODE_W-1:0] agv;
    logic [CODE_W-1:0] fgv;

    assign target = clamp_target(src_kind_e'(src_kind));

    vcag_clamp u_clamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (smp_en),
        .vblank (vblank),
        .hclamp (hclamp),
        .code   (adc_code),
        .target (target),
        .up     (clamp_up),
        .dn     (clamp_dn)
    );

    vcag_gain_acc #(
        .ACC_W    (ACC_W),
        .WHITE_PK (WHITE_PK),
        .SYNC_REF (SYNC_REF),
        .SYNC_HI  (SYNC_HI)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (smp_en),
        .vblank (vblank),
        .agc_on (agc_on),
        .hsync  (hsync),
        .code   (adc_code),
        .agv    (agv)
    );

    vcag_gain_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_en  (smp_en),
        .vblank  (vblank),
        .agv     (agv),
        .upd_lvl (upd_lvl),
        .fgv     (fgv)
    );

    assign gain_code = agc_on ? fgv : man_gain;
endmodule

// File: rtl/vcag_checker.sv
module vcag_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_en,
    input logic [8:0] adc_code,
    input logic       hclamp,
    input logic       vblank,
    input logic [2:0] src_kind,
    input logic       agc_on,
    input logic       clamp_up,
    input logic       clamp_dn,
    input logic [8:0] gain_code
);
    // R3: the two clamp commands never appear together
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(clamp_up && clamp_dn));

    // R3: outside the clamp window an enabled sample clears both commands
    a_r3_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && !hclamp) |=> (!clamp_up && !clamp_dn));

    // R2: composite source, sample below 120 inside the window raises the clamp
    a_r2_composite_low: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && hclamp && !vblank && src_kind == 3'd0 && adc_code < 9'd120)
        |=> clamp_up);

    // R2: RGB source, sample above 32 inside the window lowers the clamp
    a_r2_rgb_high: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && hclamp && !vblank && src_kind == 3'd5 && adc_code > 9'd32)
        |=> clamp_dn);

    // R4: vertical blanking clears clamp commands and holds the gain
    a_r4_vblank_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && vblank) |=> (!clamp_up && !clamp_dn));

    a_r4_vblank_gain: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && agc_on) |=> (!agc_on || $stable(gain_code)));

    // R10: idle cycles leave the clamp commands untouched
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> ($stable(clamp_up) && $stable(clamp_dn)));
endmodule

bind vcag_top vcag_checker u_vcag_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_en    (smp_en),
    .adc_code  (adc_code),
    .hclamp    (hclamp),
    .vblank    (vblank),
    .src_kind  (src_kind),
    .agc_on    (agc_on),
    .clamp_up  (clamp_up),
    .clamp_dn  (clamp_dn),
    .gain_code (gain_code)
);

// File: tb/vcag_top_tb_top.sv
module vcag_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 12;
    localparam int STEP       = 1 << (AW - 9);
    localparam int ACC_MAX    = (1 << AW) - 1;
    localparam int ACC_MID    = 1 << (AW - 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_en = 1'b0;
    logic [8:0] adc_code = '0;
    logic       hclamp = 1'b0;
    logic       hsync = 1'b0;
    logic       vblank = 1'b0;
    logic [2:0] src_kind = '0;
    logic       agc_on = 1'b1;
    logic [8:0] man_gain = 9'd77;
    logic [8:0] upd_lvl = 9'd0;
    logic       clamp_up, clamp_dn;
    logic [8:0] gain_code;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    // reference model state
    int  m_acc = ACC_MID;
    int  m_fgv = 256;
    bit  m_up = 0, m_dn = 0, m_hsp = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vcag_top #(.ACC_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .adc_code(adc_code),
        .hclamp(hclamp), .hsync(hsync), .vblank(vblank), .src_kind(src_kind),
        .agc_on(agc_on), .man_gain(man_gain), .upd_lvl(upd_lvl),
        .clamp_up(clamp_up), .clamp_dn(clamp_dn), .gain_code(gain_code)
    );

    function automatic int tgt_of(input int k);
        if (k == 2 || k == 3) return 256;
        if (k == 4 || k == 5) return 32;
        return 120;
    endfunction

    always @(posedge clk) begin
        int agv_old, d;
        if (!rst_n) begin
            m_acc = ACC_MID; m_fgv = 256; m_up = 0; m_dn = 0; m_hsp = 0;
        end else if (smp_en) begin
            agv_old = m_acc / STEP;
            if (!vblank) begin
                m_up = hclamp && (int'(adc_code) < tgt_of(src_kind));
                m_dn = hclamp && (int'(adc_code) > tgt_of(src_kind));
                d = agv_old - m_fgv;
                if (d < 0) d = -d;
                if (d >= int'(upd_lvl)) m_fgv = agv_old;
                if (agc_on) begin
                    if (adc_code == 9'd511) begin
                        m_acc = m_acc - STEP;
                        if (m_acc < 0) m_acc = 0;
                    end else if (hsync && !m_hsp) begin
                        if (adc_code > 9'd4) m_acc = (m_acc == ACC_MAX) ? ACC_MAX : m_acc + 1;
                        else if (adc_code == 9'd0) m_acc = (m_acc == 0) ? 0 : m_acc - 1;
                    end
                end
            end else begin
                m_up = 0; m_dn = 0;
            end
            m_hsp = hsync;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        check("R3 clamp_up", int'(clamp_up), int'(m_up));
        check("R2 clamp_dn", int'(clamp_dn), int'(m_dn));
        check("R7 gain_code", int'(gain_code), agc_on ? m_fgv : int'(man_gain));
    endtask

    task automatic samp(input int code, input bit hc, input bit hs, input bit vb);
        smp_en = 1; adc_code = 9'(code); hclamp = hc; hsync = hs; vblank = vb;
        tick();
    endtask

    task automatic idle();
        smp_en = 0;
        tick();
    endtask

    task automatic line(input int tip);
        samp(tip, 0, 1, 0);
        samp(60, 0, 0, 0);
    endtask

    initial begin
        int w;
        w = 0;
        while (w < 150000) begin
            @(posedge clk);
            w++;
        end
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 clamp_up", int'(clamp_up), 0);
        check("R1 clamp_dn", int'(clamp_dn), 0);
        check("R1 gain", int'(gain_code), 256);

        // R2/R3: every source type around its target, window on and off
        for (int k = 0; k < 8; k++) begin
            src_kind = 3'(k);
            samp(tgt_of(k) - 1, 1, 0, 0);
            check("R2 below target", int'(clamp_up), 1);
            idle();
            check("R10 idle holds", int'(clamp_up), 1);
            samp(tgt_of(k), 1, 0, 0);
            check("R3 equal target", int'(clamp_up | clamp_dn), 0);
            samp(tgt_of(k) + 1, 1, 0, 0);
            check("R2 above target", int'(clamp_dn), 1);
            samp(tgt_of(k) + 1, 0, 0, 0);
            check("R3 window closed", int'(clamp_dn), 0);
        end

        // R5 fast decrease on white peak, during sync too
        upd_lvl = 0;
        samp(511, 0, 0, 0);
        samp(511, 0, 1, 0);
        samp(511, 0, 0, 0);
        samp(60, 0, 0, 0);
        check("R5 white peak", int'(gain_code), 253);

        // R6 slow per-line increase, once per pulse
        for (int i = 0; i < 16; i++) begin
            samp(20, 0, 1, 0); samp(20, 0, 1, 0); idle(); samp(20, 0, 1, 0);
            samp(60, 0, 0, 0);
        end
        samp(60, 0, 0, 0);
        check("R6 slow rise", int'(gain_code), 255);
        line(2); line(3);
        check("R6 dead band", int'(gain_code), 255);
        line(0); samp(60, 0, 0, 0);
        check("R6 slow fall", int'(gain_code), 254);

        // R7 hysteresis on held gain
        upd_lvl = 4;
        repeat (3) samp(511, 0, 0, 0);
        samp(60, 0, 0, 0);
        check("R7 below update level", int'(gain_code), 254);
        samp(511, 0, 0, 0);
        samp(60, 0, 0, 0);
        check("R7 at update level", int'(gain_code), 250);

        // R4 vertical blanking freezes both loops
        upd_lvl = 0;
        src_kind = 3'd0;
        repeat (5) samp(511, 1, 0, 1);
        line(0);
        samp(10, 1, 0, 1);
        check("R4 clamp frozen", int'(clamp_up | clamp_dn), 0);
        samp(60, 0, 0, 0);
        check("R4 gain frozen", int'(gain_code), 250);

        // R9 manual gain, accumulator untouched
        agc_on = 0;
        samp(60, 0, 0, 0);
        check("R9 manual gain", int'(gain_code), 77);
        repeat (4) samp(511, 0, 0, 0);
        line(0);
        agc_on = 1;
        samp(60, 0, 0, 0);
        check("R9 acc held", int'(gain_code), 250);

        // R8 saturation at both ends
        repeat (300) samp(511, 0, 0, 0);
        line(0); samp(60, 0, 0, 0);
        check("R8 floor", int'(gain_code), 0);
        repeat (4200) line(20);
        samp(60, 0, 0, 0);
        check("R8 ceiling", int'(gain_code), 511);
        samp(511, 0, 0, 0); samp(60, 0, 0, 0);
        check("R8 no wrap", int'(gain_code), 510);

        // R1 reset again mid-run
        rst_n = 0; smp_en = 0;
        tick();
        rst_n = 1;
        @(negedge clk);
        check("R1 reset gain", int'(gain_code), 256);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule